// File: doc/BRIEF.md
# Burst Dual-Port Synchronous RAM

This block is a true dual-port static RAM with two fully independent ports, A and B. Each port runs on its own clock. Each port captures its address, write data, byte-lane enables, read/write select and a pair of chip selects on the rising edge of that clock. The storage holds 36-bit words split into four 9-bit byte lanes. The depth is 2^ADDR_W words.

Each port owns a burst address counter. A load strobe sets the counter from the external address. A replay input returns it to the address last loaded. A step input advances it by one, wrapping at the top of memory. When none of these is asserted the counter holds, so a burst can stall for as long as needed. Every access uses the counter value chosen at the capturing edge.

The two chip selects have opposite polarity: one is active low, the other active high. This lets an address bit steer two devices in a depth-expanded pair without glue logic. One unselected cycle stops the port. Two selected cycles in a row are needed before read data is driven again. The output enable acts combinationally on the output drivers. A drive flag stands in for tri-state buffers.

Top module: `burst_dpram`

## Requirements
- R1: While reset is held and after its release, with no read issued, both ports show `*_q_drv` = 0 and `*_q` = 0.
- R2: `*_rd` = 1 captured on a selected edge k reads the word at the counter address. With output enable high, that word is driven on `*_q` after edge k+1 and until edge k+2. `*_rd` = 0 writes instead.
- R3: A selected edge with `*_load` = 1 sets the counter and the replay base to `*_addr`. Load wins over replay and step.
- R4: A selected edge with `*_replay` = 1 and no load sets the counter to the address of the last load. Replay wins over step.
- R5: A selected edge with only `*_step` = 1 adds one to the counter. Address 2^ADDR_W-1 is followed by 0.
- R6: The counter keeps its value on an edge where the port is unselected, or where load, replay and step are all 0. An unselected edge performs no read and no write.
- R7: A write changes only the byte lanes whose `*_lane` bit is 1. Lane bit l covers word bits 9l+8 down to 9l.
- R8: The port is selected on an edge when `*_cs_n` = 0 and `*_cs` = 1. Any edge where it is not selected suppresses output drive two and three edges later. A read is driven only if the edge before the read's edge was also selected.
- R9: `*_q_drv` is 1 only while `*_oe` is 1. It follows `*_oe` with no clock. While `*_q_drv` is 0, `*_q` is 0.
- R10: Each port sees the data written by the other port. This holds under separate clocks and holds per byte lane, with the later write winning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released per port clock |
| a_clk | input | 1 | Port A clock |
| a_cs_n | input | 1 | Port A select, active low |
| a_cs | input | 1 | Port A select, active high |
| a_rd | input | 1 | Port A access type: 1 read, 0 write |
| a_lane | input | 4 | Port A byte-lane write enables |
| a_addr | input | ADDR_W | Port A external address |
| a_load | input | 1 | Port A counter load strobe |
| a_step | input | 1 | Port A counter advance enable |
| a_replay | input | 1 | Port A counter return to loaded address |
| a_din | input | 36 | Port A write data |
| a_oe | input | 1 | Port A output enable, asynchronous |
| a_q | output | 36 | Port A read data |
| a_q_drv | output | 1 | Port A output drivers on |
| b_clk | input | 1 | Port B clock |
| b_cs_n | input | 1 | Port B select, active low |
| b_cs | input | 1 | Port B select, active high |
| b_rd | input | 1 | Port B access type: 1 read, 0 write |
| b_lane | input | 4 | Port B byte-lane write enables |
| b_addr | input | ADDR_W | Port B external address |
| b_load | input | 1 | Port B counter load strobe |
| b_step | input | 1 | Port B counter advance enable |
| b_replay | input | 1 | Port B counter return to loaded address |
| b_din | input | 36 | Port B write data |
| b_oe | input | 1 | Port B output enable, asynchronous |
| b_q | output | 36 | Port B read data |
| b_q_drv | output | 1 | Port B output drivers on |

## Verification
The hardest case to reach from the ports is a word whose byte lanes were last written by different ports. Only then must the read merge lanes from both storage banks. The stimulus writes a full word from port A and overwrites two lanes from port B on its own skewed clock. It then reads the word back through A and rewrites one lane from A. The pins also cannot show the counter directly. So it is exposed through reads that follow replay, held-step and wrap sequences, and through reads placed right after an unselected edge.

// File: rtl/burst_dpram_pkg.sv
package burst_dpram_pkg;
  localparam int WORD_W = 36;
  localparam int LANES  = 4;
  localparam int LANE_W = WORD_W / LANES;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lane_t;
endpackage

// File: rtl/burst_dpram_rsync.sv
module burst_dpram_rsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/burst_dpram_port.sv
module burst_dpram_port
  import burst_dpram_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              cs,
  input  logic              rd,
  input  lane_t             lane,
  input  logic [ADDR_W-1:0] addr,
  input  logic              load,
  input  logic              step,
  input  logic              replay,
  input  word_t             din,
  input  word_t             rdata,
  output logic              rst_sn,
  output logic [ADDR_W-1:0] cnt,
  output logic              wr_en,
  output lane_t             wr_lane,
  output word_t             wr_data,
  output word_t             q,
  output logic              q_vld
);
  logic              sel_d;
  logic [ADDR_W-1:0] cnt_d, base_d;
  logic [ADDR_W-1:0] cnt_q, base_q;
  logic              sel_q, prev_q, rd_q, wr_q, qv_q;
  lane_t             lane_q;
  word_t             din_q, q_q;

  burst_dpram_rsync u_rsync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  // next-state: counter priority load > replay > step, frozen when unselected
  always_comb begin
    sel_d  = ~cs_n & cs;
    cnt_d  = cnt_q;
    base_d = base_q;
    if (sel_d) begin
      if (load) begin
        cnt_d  = addr;
        base_d = addr;
      end else if (replay) begin
        cnt_d  = base_q;
      end else if (step) begin
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cnt_q  <= '0;
      base_q <= '0;
      sel_q  <= 1'b0;
      prev_q <= 1'b0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      lane_q <= '0;
      din_q  <= '0;
      qv_q   <= 1'b0;
      q_q    <= '0;
    end else begin
      cnt_q  <= cnt_d;
      base_q <= base_d;
      sel_q  <= sel_d;
      prev_q <= sel_q;
      rd_q   <= sel_d & rd;
      wr_q   <= sel_d & ~rd;
      lane_q <= lane;
      din_q  <= din;
      qv_q   <= rd_q & prev_q;
      if (rd_q) q_q <= rdata;
    end
  end

  assign cnt     = cnt_q;
  assign wr_en   = wr_q;
  assign wr_lane = lane_q;
  assign wr_data = din_q;
  assign q       = q_q;
  assign q_vld   = qv_q;
endmodule

// File: rtl/burst_dpram_bank.sv
module burst_dpram_bank
  import burst_dpram_pkg::*;
#(
  parameter int   ADDR_W = 9,
  parameter logic FLIP   = 1'b0
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  lane_t             wlane,
  input  word_t             wdata,
  input  lane_t             peer_tag,
  input  logic [ADDR_W-1:0] raddr0,
  input  logic [ADDR_W-1:0] raddr1,
  output word_t             rdata0,
  output word_t             rdata1,
  output lane_t             rtag0,
  output lane_t             rtag1
);
  localparam int DEPTH = 1 << ADDR_W;

  word_t mem_q [DEPTH];
  lane_t tag_q [DEPTH];

  // one writer per bank; the lane tag records which bank holds the newest lane
  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < LANES; l++) begin
        if (wlane[l]) begin
          mem_q[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
          tag_q[waddr][l]                  <= peer_tag[l] ^ FLIP;
        end
      end
    end
  end

  assign rdata0 = mem_q[raddr0];
  assign rdata1 = mem_q[raddr1];
  assign rtag0  = tag_q[raddr0];
  assign rtag1  = tag_q[raddr1];
endmodule

// File: rtl/burst_dpram.sv
module burst_dpram
  import burst_dpram_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              rst_n,
  input  logic              a_clk,
  input  logic              a_cs_n,
  input  logic              a_cs,
  input  logic              a_rd,
  input  logic [3:0]        a_lane,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_load,
  input  logic              a_step,
  input  logic              a_replay,
  input  logic [35:0]       a_din,
  input  logic              a_oe,
  output logic [35:0]       a_q,
  output logic              a_q_drv,
  input  logic              b_clk,
  input  logic              b_cs_n,
  input  logic              b_cs,
  input  logic              b_rd,
  input  logic [3:0]        b_lane,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_load,
  input  logic              b_step,
  input  logic              b_replay,
  input  logic [35:0]       b_din,
  input  logic              b_oe,
  output logic [35:0]       b_q,
  output logic              b_q_drv
);
  logic              clk_v [2], cs_n_v [2], cs_v [2], rd_v [2];
  logic              load_v [2], step_v [2], replay_v [2];
  lane_t             lane_v [2], wlane_v [2];
  logic [ADDR_W-1:0] addr_v [2], cnt_v [2];
  word_t             din_v [2], wdata_v [2], q_v [2];
  logic              rst_sv [2], wen_v [2], qvld_v [2];
  word_t             bk_d [2][2];
  lane_t             bk_t [2][2];

  logic              a_rst_s, b_rst_s;
  logic [ADDR_W-1:0] a_cnt, b_cnt;

  assign clk_v[0] = a_clk;    assign clk_v[1] = b_clk;
  assign cs_n_v[0] = a_cs_n;  assign cs_n_v[1] = b_cs_n;
  assign cs_v[0] = a_cs;      assign cs_v[1] = b_cs;
  assign rd_v[0] = a_rd;      assign rd_v[1] = b_rd;
  assign lane_v[0] = a_lane;  assign lane_v[1] = b_lane;
  assign addr_v[0] = a_addr;  assign addr_v[1] = b_addr;
  assign load_v[0] = a_load;  assign load_v[1] = b_load;
  assign step_v[0] = a_step;  assign step_v[1] = b_step;
  assign replay_v[0] = a_replay; assign replay_v[1] = b_replay;
  assign din_v[0] = a_din;    assign din_v[1] = b_din;

  for (genvar p = 0; p < 2; p++) begin : g_side
    word_t merged;

    // per lane, tags that differ point at bank 1 as the later writer
    always_comb begin
      for (int l = 0; l < LANES; l++) begin
        merged[l*LANE_W +: LANE_W] = (bk_t[0][p][l] ^ bk_t[1][p][l])
                                   ? bk_d[1][p][l*LANE_W +: LANE_W]
                                   : bk_d[0][p][l*LANE_W +: LANE_W];
      end
    end

    burst_dpram_port #(.ADDR_W(ADDR_W)) u_port (
      .clk     (clk_v[p]),
      .rst_n   (rst_n),
      .cs_n    (cs_n_v[p]),
      .cs      (cs_v[p]),
      .rd      (rd_v[p]),
      .lane    (lane_v[p]),
      .addr    (addr_v[p]),
      .load    (load_v[p]),
      .step    (step_v[p]),
      .replay  (replay_v[p]),
      .din     (din_v[p]),
      .rdata   (merged),
      .rst_sn  (rst_sv[p]),
      .cnt     (cnt_v[p]),
      .wr_en   (wen_v[p]),
      .wr_lane (wlane_v[p]),
      .wr_data (wdata_v[p]),
      .q       (q_v[p]),
      .q_vld   (qvld_v[p])
    );

    burst_dpram_bank #(.ADDR_W(ADDR_W), .FLIP(1'(p))) u_bank (
      .clk      (clk_v[p]),
      .we       (wen_v[p]),
      .waddr    (cnt_v[p]),
      .wlane    (wlane_v[p]),
      .wdata    (wdata_v[p]),
      .peer_tag (bk_t[1-p][p]),
      .raddr0   (cnt_v[0]),
      .raddr1   (cnt_v[1]),
      .rdata0   (bk_d[p][0]),
      .rdata1   (bk_d[p][1]),
      .rtag0    (bk_t[p][0]),
      .rtag1    (bk_t[p][1])
    );
  end

  assign a_rst_s = rst_sv[0];
  assign b_rst_s = rst_sv[1];
  assign a_cnt   = cnt_v[0];
  assign b_cnt   = cnt_v[1];

  assign a_q_drv = a_oe & qvld_v[0];
  assign b_q_drv = b_oe & qvld_v[1];
  assign a_q     = a_q_drv ? q_v[0] : '0;
  assign b_q     = b_q_drv ? q_v[1] : '0;
endmodule

// File: rtl/burst_dpram_chk.sv
module burst_dpram_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_sn,
  input logic              cs_n,
  input logic              cs,
  input logic              load,
  input logic              replay,
  input logic              step,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] cnt,
  input logic              oe,
  input logic [35:0]       q,
  input logic              q_drv
);
  logic              sel;
  logic [ADDR_W-1:0] shadow_q;

  assign sel = ~cs_n & cs;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)          shadow_q <= '0;
    else if (sel && load) shadow_q <= addr;
  end

  // R3
  load_sets_counter_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (sel && load) |=> cnt == $past(addr));

  // R4
  replay_returns_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (sel && !load && replay) |=> cnt == $past(shadow_q));

  // R5
  step_advances_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (sel && !load && !replay && step) |=> cnt == ADDR_W'($past(cnt) + 1'b1));

  // R6
  counter_holds_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!sel || !(load || replay || step)) |=> $stable(cnt));

  // R8
  deselect_mutes_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !sel |-> ##2 !q_drv ##1 !q_drv);

  // R9
  drive_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    q_drv |-> oe);

  // R9
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !q_drv |-> q == '0);
endmodule

bind burst_dpram burst_dpram_chk #(.ADDR_W(ADDR_W)) u_chk_a (
  .clk(a_clk), .rst_sn(a_rst_s), .cs_n(a_cs_n), .cs(a_cs), .load(a_load),
  .replay(a_replay), .step(a_step), .addr(a_addr), .cnt(a_cnt), .oe(a_oe),
  .q(a_q), .q_drv(a_q_drv)
);

bind burst_dpram burst_dpram_chk #(.ADDR_W(ADDR_W)) u_chk_b (
  .clk(b_clk), .rst_sn(b_rst_s), .cs_n(b_cs_n), .cs(b_cs), .load(b_load),
  .replay(b_replay), .step(b_step), .addr(b_addr), .cnt(b_cnt), .oe(b_oe),
  .q(b_q), .q_drv(b_q_drv)
);

// File: tb/test_burst_dpram.sv
`timescale 1ns/1ps
module test_burst_dpram;
  localparam int AW = 9;

  logic          rst_n;
  logic          a_clk, a_cs_n, a_cs, a_rd, a_load, a_step, a_replay, a_oe, a_q_drv;
  logic [3:0]    a_lane;
  logic [AW-1:0] a_addr;
  logic [35:0]   a_din, a_q;
  logic          b_clk, b_cs_n, b_cs, b_rd, b_load, b_step, b_replay, b_oe, b_q_drv;
  logic [3:0]    b_lane;
  logic [AW-1:0] b_addr;
  logic [35:0]   b_din, b_q;

  burst_dpram #(.ADDR_W(AW)) i_burst_dpram (
    .rst_n, .a_clk, .a_cs_n, .a_cs, .a_rd, .a_lane, .a_addr, .a_load, .a_step,
    .a_replay, .a_din, .a_oe, .a_q, .a_q_drv, .b_clk, .b_cs_n, .b_cs, .b_rd,
    .b_lane, .b_addr, .b_load, .b_step, .b_replay, .b_din, .b_oe, .b_q, .b_q_drv
  );

  initial begin a_clk = 0; forever #5 a_clk = ~a_clk; end
  initial begin b_clk = 0; #3; forever #5 b_clk = ~b_clk; end

  typedef struct { int due; bit vld; logic [35:0] data; string req; } exp_t;
  exp_t sbq[$];
  exp_t mon_e;

  int total = 0, bad = 0, cyc_a = 0;
  bit done = 0;

  logic [35:0]   mdl [1 << AW];
  logic [AW-1:0] ma_cnt, ma_base, mb_cnt, mb_base;
  bit            ma_prev;

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(posedge a_clk) cyc_a = cyc_a + 1;

  // monitor: one scoreboard item per port A edge, compared after the next edge
  always @(negedge a_clk) begin
    if (sbq.size() > 0 && sbq[0].due <= cyc_a) begin
      mon_e = sbq.pop_front();
      check(mon_e.req, "drive/data",
            {27'd0, a_q_drv, a_q},
            {27'd0, (mon_e.vld && a_oe), ((mon_e.vld && a_oe) ? mon_e.data : 36'd0)});
    end
  end

  function automatic void mdl_write(logic [AW-1:0] ad, logic [3:0] ln, logic [35:0] d);
    for (int l = 0; l < 4; l++)
      if (ln[l]) mdl[ad][l*9 +: 9] = d[l*9 +: 9];
  endfunction

  // driver for port A: drives one edge, updates the model, queues the expectation
  task automatic a_cyc(bit cs_n, bit cs, bit rd, logic [3:0] ln, logic [AW-1:0] ad,
                       bit ld, bit st, bit rp, logic [35:0] d, string req);
    bit sel;
    exp_t e;
    a_cs_n = cs_n; a_cs = cs; a_rd = rd; a_lane = ln; a_addr = ad;
    a_load = ld; a_step = st; a_replay = rp; a_din = d;
    sel = !cs_n && cs;
    if (sel) begin
      if (ld) begin ma_cnt = ad; ma_base = ad; end
      else if (rp) ma_cnt = ma_base;
      else if (st) ma_cnt = ma_cnt + 1'b1;
      if (!rd) mdl_write(ma_cnt, ln, d);
    end
    e.vld  = sel && rd && ma_prev;
    e.data = mdl[ma_cnt];
    e.req  = req;
    ma_prev = sel;
    @(posedge a_clk);
    #1;
    e.due = cyc_a + 1;
    sbq.push_back(e);
  endtask

  task automatic a_idle(string req);
    a_cyc(0, 1, 0, 4'h0, '0, 0, 0, 0, '0, req);
  endtask

  task automatic a_rdc(logic [AW-1:0] ad, bit ld, bit st, bit rp, string req);
    a_cyc(0, 1, 1, 4'h0, ad, ld, st, rp, '0, req);
  endtask

  task automatic a_wrc(logic [AW-1:0] ad, bit ld, bit st, logic [3:0] ln,
                       logic [35:0] d, string req);
    a_cyc(0, 1, 0, ln, ad, ld, st, 0, d, req);
  endtask

  task automatic b_wr(logic [AW-1:0] ad, bit ld, bit st, logic [3:0] ln, logic [35:0] d);
    b_cs_n = 0; b_cs = 1; b_rd = 0; b_lane = ln; b_addr = ad;
    b_load = ld; b_step = st; b_replay = 0; b_din = d;
    if (ld) begin mb_cnt = ad; mb_base = ad; end
    else if (st) mb_cnt = mb_cnt + 1'b1;
    mdl_write(mb_cnt, ln, d);
    @(posedge b_clk);
    #1;
  endtask

  task automatic b_off();
    b_cs_n = 1; b_load = 0; b_step = 0; b_lane = 4'h0;
    @(posedge b_clk);
    #1;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    a_cs_n = 1; a_cs = 0; a_rd = 0; a_lane = 0; a_addr = 0; a_load = 0;
    a_step = 0; a_replay = 0; a_din = 0; a_oe = 1;
    b_cs_n = 1; b_cs = 0; b_rd = 0; b_lane = 0; b_addr = 0; b_load = 0;
    b_step = 0; b_replay = 0; b_din = 0; b_oe = 1;
    ma_cnt = 0; ma_base = 0; mb_cnt = 0; mb_base = 0; ma_prev = 0;
    for (int i = 0; i < (1 << AW); i++) mdl[i] = '0;
    repeat (3) @(posedge a_clk);
    #1;
    check("R1", "a drive in reset", {63'd0, a_q_drv}, 64'd0);
    rst_n = 1;
    repeat (4) @(posedge a_clk);
    #1;
    check("R1", "a bus after reset", {27'd0, a_q_drv, a_q}, 64'd0);
    check("R1", "b bus after reset", {27'd0, b_q_drv, b_q}, 64'd0);

    // R8: two selected cycles to arm the outputs
    a_idle("R8"); a_idle("R8");

    // R2 R3 R5: burst write then burst read
    a_wrc(9'd5, 1, 0, 4'hF, 36'h1_2345_6789, "R3");
    a_wrc(9'd0, 0, 1, 4'hF, 36'hA_BCDE_F012, "R5");
    a_wrc(9'd0, 0, 1, 4'hF, 36'h5_5AA5_A55A, "R5");
    a_rdc(9'd5, 1, 0, 0, "R2");
    a_rdc(9'd0, 0, 1, 0, "R5");
    a_rdc(9'd0, 0, 1, 0, "R5");
    a_idle("R2");

    // R7: lanes 0 and 2 only
    a_wrc(9'd5, 1, 0, 4'b0101, 36'hF_FFFF_FFFF, "R7");
    a_rdc(9'd5, 1, 0, 0, "R7");
    a_idle("R7");

    // R4: replay to the loaded address, replay beats step
    a_wrc(9'd10, 1, 0, 4'hF, 36'h0_1010_1010, "R4");
    a_wrc(9'd0, 0, 1, 4'hF, 36'h0_1111_1111, "R4");
    a_wrc(9'd0, 0, 1, 4'hF, 36'h0_1212_1212, "R4");
    a_rdc(9'd10, 1, 0, 0, "R4");
    a_rdc(9'd0, 0, 1, 0, "R4");
    a_rdc(9'd0, 0, 0, 1, "R4");
    a_rdc(9'd0, 0, 1, 1, "R4");
    a_idle("R4");

    // R6: no control asserted keeps the address
    a_rdc(9'd11, 1, 0, 0, "R6");
    a_rdc(9'd77, 0, 0, 0, "R6");
    a_idle("R6");

    // R5: wrap from top of memory to zero
    a_wrc(9'd511, 1, 0, 4'hF, 36'h9_0000_01FF, "R5");
    a_wrc(9'd0, 0, 1, 4'hF, 36'h3_0000_0000, "R5");
    a_rdc(9'd511, 1, 0, 0, "R5");
    a_rdc(9'd0, 0, 1, 0, "R5");
    a_idle("R5");

    // R8 R6: active-low select off, counter frozen, reactivation takes two cycles
    a_rdc(9'd12, 1, 0, 0, "R8");
    a_cyc(1, 1, 1, 4'h0, 9'd0, 0, 1, 0, '0, "R8");
    a_rdc(9'd0, 0, 0, 0, "R8");
    a_rdc(9'd0, 0, 0, 0, "R6");
    // active-high select off with a write pending: write is dropped
    a_cyc(0, 0, 0, 4'hF, 9'd0, 0, 0, 0, 36'hD_EADB_EEF0, "R6");
    a_rdc(9'd0, 0, 0, 0, "R8");
    a_rdc(9'd0, 0, 0, 0, "R6");
    a_idle("R6");

    // R9: output enable acts without a clock
    a_oe = 0;
    a_rdc(9'd5, 1, 0, 0, "R9");
    a_idle("R9");
    #1;
    check("R9", "oe low drive", {27'd0, a_q_drv, a_q}, 64'd0);
    a_oe = 1;
    #1;
    check("R9", "oe high drive", {27'd0, a_q_drv, a_q}, {27'd0, 1'b1, mdl[5]});
    a_idle("R9");

    // R10: cross-port data, lane-wise newest writer wins
    a_wrc(9'd30, 1, 0, 4'hF, 36'h7_7777_7777, "R10");
    a_idle("R10");
    b_wr(9'd30, 1, 0, 4'b0011, 36'h0_0000_3C3C);
    b_wr(9'd40, 1, 0, 4'hF, 36'hB_0B0B_0B0B);
    b_wr(9'd0, 0, 1, 4'hF, 36'hC_0C0C_0C0C);
    b_off(); b_off();
    a_rdc(9'd30, 1, 0, 0, "R10");
    a_rdc(9'd40, 1, 0, 0, "R10");
    a_rdc(9'd0, 0, 1, 0, "R10");
    a_wrc(9'd30, 1, 0, 4'b0001, 36'h0_0000_01AA, "R10");
    a_rdc(9'd30, 1, 0, 0, "R10");
    a_idle("R10");
    a_idle("R10");

    repeat (4) @(posedge a_clk);
    #1;
    check("R2", "scoreboard drained", 64'(sbq.size()), 64'd0);
    done = 1;
    summary();
    $finish;
  end
endmodule